// File: doc/BRIEF.md
# Audio Controller Interrupt Status Aggregator

This block collects the interrupt status of a multi-stream audio controller and folds it into a single 32-bit read-only status word. Each stream's owner presents a vector of level-held status sources. The block reduces each vector to one bit per stream, with the input streams first and the output streams after them. It also reduces three controller-level events into one controller bit. A global bit summarises the whole word. Status is captured regardless of any enable. The enables only gate the single registered interrupt request line.

A free-running wall clock counter sits next to the status word. It advances once per link bit-clock period while the link clock is enabled, and it wraps at 32 bits. Both registers are reached through one small registered read port, at two fixed offsets. A test hook can preload the counter so that its wrap can be reached quickly.

Top module: `audio_irq_aggregator`

## Requirements
- R1: Status bits 0 to 3 belong to input streams 1 to 4, and bits 4 to 7 belong to output streams 1 to 4. Each stream bit is the OR of that stream's three status sources, and `in_src[3k+j]` is source j of input stream k+1.
- R2: Bit 30 is the OR of the response interrupt, the response buffer overrun and the serial data-in state change.
- R3: Bit 31, and the `global_sum` output, is the OR of bit 30 and bits 7:0.
- R4: Bits 29:8 of the status word are always zero.
- R5: Status bits follow their sources whatever the state of any enable.
- R6: `irq_req` is registered. One cycle after the inputs are presented, it equals `glob_en` AND (any stream bit set whose `stream_en` bit is set, OR bit 30 set with `ctrl_en` set). It stays low when a status bit is set but its enable is clear.
- R7: While `rst_n` is low, `rd_data`, `irq_req` and the wall clock are all zero.
- R8: The wall clock rises by one on each clock where `link_clk_en` and `bclk_tick` are both 1. It holds when `link_clk_en` is 0.
- R9: The wall clock wraps from FFFF_FFFFh to 0000_0000h.
- R10: A read (`rd_en`=1, `wr_en`=0) at offset 24h returns the status word on the next cycle, and a read at offset 30h returns the wall clock value from before that edge. A read at any other offset returns zero.
- R11: A cycle with `wr_en`=1 leaves `rd_data`, the wall clock and the status word unchanged.
- R12: When `tst_load` is 1, the wall clock takes `tst_value` at the next edge, and this takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Controller reset, active low |
| in_src | input | 12 | Status sources of the input streams, three per stream |
| out_src | input | 12 | Status sources of the output streams, three per stream |
| rsp_irq | input | 1 | Response interrupt event |
| rsp_ovr | input | 1 | Response buffer overrun event |
| sdin_chg | input | 1 | Serial data-in state change event |
| stream_en | input | 8 | Per-stream interrupt enables, same order as status bits 7:0 |
| ctrl_en | input | 1 | Controller interrupt enable |
| glob_en | input | 1 | Global interrupt enable |
| link_clk_en | input | 1 | Link clock enable, gates the wall clock |
| bclk_tick | input | 1 | One-cycle pulse per link bit-clock period |
| tst_load | input | 1 | Test hook: preload the wall clock |
| tst_value | input | 32 | Test hook preload value |
| rd_en | input | 1 | Register access strobe |
| wr_en | input | 1 | Access is a write (ignored) |
| rd_addr | input | 8 | Access byte offset |
| rd_data | output | 32 | Registered read data |
| status_word | output | 32 | Live status word |
| global_sum | output | 1 | Global status summary |
| irq_req | output | 1 | Registered, enable-gated interrupt request |

## Verification
Two functions can act on the same edge: a wall clock read and a wall clock increment. The bench starts the counter ticking on exactly the edge that samples a read at 30h. It expects the pre-increment value on the port, and expects later reads to show every increment, including one across the 32-bit wrap. Status changes and interrupt gating also meet on one edge. Every one of the 256 stream patterns is driven together with a shifting enable mask. In that same cycle the bench compares the combinational word with the registered request.

// File: rtl/aia_pkg.sv
package aia_pkg;
   localparam int unsigned WORD_W  = 32;
   localparam int unsigned GIS_POS = 31;
   localparam int unsigned CIS_POS = 30;
   localparam int unsigned MAX_STREAMS = 30;

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_STATUS = 2'd1,
      SEL_CLOCK  = 2'd2
   } rd_sel_e;
endpackage

// File: rtl/aia_stream_or.sv
module aia_stream_or #(
   parameter int unsigned NUM_STREAMS = 8,
   parameter int unsigned SRC_PER     = 3
) (
   input  logic [NUM_STREAMS*SRC_PER-1:0] src,
   output logic [NUM_STREAMS-1:0]         bits
);
   generate
      for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
         assign bits[s] = |src[s*SRC_PER +: SRC_PER];
      end
   endgenerate
endmodule

// File: rtl/aia_status_pack.sv
module aia_status_pack
   import aia_pkg::*;
#(
   parameter int unsigned NUM_STREAMS = 8
) (
   input  logic [NUM_STREAMS-1:0] stream_bits,
   input  logic                   rsp_irq,
   input  logic                   rsp_ovr,
   input  logic                   sdin_chg,
   output logic [WORD_W-1:0]      word,
   output logic                   ctrl_bit,
   output logic                   glob_bit
);
   localparam int unsigned PAD_W = CIS_POS - NUM_STREAMS;

   assign ctrl_bit = rsp_irq | rsp_ovr | sdin_chg;
   assign glob_bit = ctrl_bit | (|stream_bits);

   generate
      if (PAD_W > 0) begin : g_pad
         assign word = {glob_bit, ctrl_bit, {PAD_W{1'b0}}, stream_bits};
      end else begin : g_nopad
         assign word = {glob_bit, ctrl_bit, stream_bits};
      end
   endgenerate
endmodule

// File: rtl/aia_wall_clock.sv
module aia_wall_clock #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           count <= '0;
      else if (load)        count <= load_val;
      else if (run && tick) count <= count + 1'b1;
   end
endmodule

// File: rtl/aia_irq_gate.sv
module aia_irq_gate #(
   parameter int unsigned NUM_STREAMS = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_STREAMS-1:0] stream_bits,
   input  logic [NUM_STREAMS-1:0] stream_en,
   input  logic                   ctrl_bit,
   input  logic                   ctrl_en,
   input  logic                   glob_en,
   output logic                   irq
);
   logic pend;
   assign pend = (|(stream_bits & stream_en)) | (ctrl_bit & ctrl_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= glob_en & pend;
   end
endmodule

// File: rtl/aia_read_port.sv
module aia_read_port
   import aia_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] STATUS_OFS = 'h24,
   parameter logic [ADDR_W-1:0] CLOCK_OFS  = 'h30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              acc_wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] status_word,
   input  logic [WORD_W-1:0] clock_val,
   output logic [WORD_W-1:0] data
);
   rd_sel_e          sel;
   logic [WORD_W-1:0] mux;

   always_comb begin
      if (addr == STATUS_OFS)     sel = SEL_STATUS;
      else if (addr == CLOCK_OFS) sel = SEL_CLOCK;
      else                        sel = SEL_NONE;
   end

   always_comb begin
      unique case (sel)
         SEL_STATUS: mux = status_word;
         SEL_CLOCK:  mux = clock_val;
         default:    mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                data <= '0;
      else if (acc_en && !acc_wr) data <= mux;
   end
endmodule

// File: rtl/audio_irq_aggregator.sv
module audio_irq_aggregator
   import aia_pkg::*;
#(
   parameter int unsigned NUM_IN     = 4,
   parameter int unsigned NUM_OUT    = 4,
   parameter int unsigned SRC_PER    = 3,
   parameter int unsigned ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] STATUS_OFS = 'h24,
   parameter logic [ADDR_W-1:0] CLOCK_OFS  = 'h30,
   localparam int unsigned NUM_STREAMS = NUM_IN + NUM_OUT
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_IN*SRC_PER-1:0] in_src,
   input  logic [NUM_OUT*SRC_PER-1:0] out_src,
   input  logic                      rsp_irq,
   input  logic                      rsp_ovr,
   input  logic                      sdin_chg,
   input  logic [NUM_STREAMS-1:0]    stream_en,
   input  logic                      ctrl_en,
   input  logic                      glob_en,
   input  logic                      link_clk_en,
   input  logic                      bclk_tick,
   input  logic                      tst_load,
   input  logic [WORD_W-1:0]         tst_value,
   input  logic                      rd_en,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         rd_addr,
   output logic [WORD_W-1:0]         rd_data,
   output logic [WORD_W-1:0]         status_word,
   output logic                      global_sum,
   output logic                      irq_req
);
   generate
      if (NUM_STREAMS > MAX_STREAMS || NUM_STREAMS == 0) begin : g_bad_streams
         $error("stream count must be 1..%0d", MAX_STREAMS);
      end
      if (SRC_PER == 0) begin : g_bad_src
         $error("each stream needs at least one source");
      end
      if (STATUS_OFS == CLOCK_OFS) begin : g_bad_ofs
         $error("register offsets must differ");
      end
   endgenerate

   logic [NUM_STREAMS*SRC_PER-1:0] all_src;
   logic [NUM_STREAMS-1:0]         stream_bits;
   logic                           ctrl_bit;
   logic                           glob_bit;
   logic [WORD_W-1:0]              wall_cnt;

   // input streams occupy the low positions, output streams follow
   assign all_src = {out_src, in_src};

   aia_stream_or #(.NUM_STREAMS(NUM_STREAMS), .SRC_PER(SRC_PER)) u_or (
      .src  (all_src),
      .bits (stream_bits)
   );

   aia_status_pack #(.NUM_STREAMS(NUM_STREAMS)) u_pack (
      .stream_bits (stream_bits),
      .rsp_irq     (rsp_irq),
      .rsp_ovr     (rsp_ovr),
      .sdin_chg    (sdin_chg),
      .word        (status_word),
      .ctrl_bit    (ctrl_bit),
      .glob_bit    (glob_bit)
   );

   assign global_sum = glob_bit;

   aia_irq_gate #(.NUM_STREAMS(NUM_STREAMS)) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .stream_bits (stream_bits),
      .stream_en   (stream_en),
      .ctrl_bit    (ctrl_bit),
      .ctrl_en     (ctrl_en),
      .glob_en     (glob_en),
      .irq         (irq_req)
   );

   aia_wall_clock #(.CNT_W(WORD_W)) u_clock (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (link_clk_en),
      .tick     (bclk_tick),
      .load     (tst_load),
      .load_val (tst_value),
      .count    (wall_cnt)
   );

   aia_read_port #(
      .ADDR_W     (ADDR_W),
      .STATUS_OFS (STATUS_OFS),
      .CLOCK_OFS  (CLOCK_OFS)
   ) u_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc_en      (rd_en),
      .acc_wr      (wr_en),
      .addr        (rd_addr),
      .status_word (status_word),
      .clock_val   (wall_cnt),
      .data        (rd_data)
   );
endmodule

// File: rtl/aia_checker.sv
module aia_checker #(
   parameter int unsigned NUM_STREAMS = 8,
   parameter int unsigned ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] STATUS_OFS = 'h24,
   parameter logic [ADDR_W-1:0] CLOCK_OFS  = 'h30
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [31:0]            status_word,
   input logic                   global_sum,
   input logic                   irq_req,
   input logic [NUM_STREAMS-1:0] stream_en,
   input logic                   ctrl_en,
   input logic                   glob_en,
   input logic                   link_clk_en,
   input logic                   bclk_tick,
   input logic                   tst_load,
   input logic                   rd_en,
   input logic                   wr_en,
   input logic [ADDR_W-1:0]      rd_addr,
   input logic [31:0]            rd_data,
   input logic [31:0]            wall_cnt
);
   logic want_irq;
   assign want_irq = glob_en &&
      ((|(status_word[NUM_STREAMS-1:0] & stream_en)) || (status_word[30] && ctrl_en));

   p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      want_irq |=> irq_req);
   p_irq_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !want_irq |=> !irq_req);

   p_summary_r3: assert property (@(posedge clk) disable iff (!rst_n)
      global_sum == (status_word[30] || (|status_word[NUM_STREAMS-1:0])));

   p_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && rd_addr == STATUS_OFS) |=> (rd_data[29:8] == 22'd0));

   p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_clk_en && !tst_load) |=> $stable(wall_cnt));

   p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (link_clk_en && bclk_tick && !tst_load && wall_cnt != 32'hFFFF_FFFF)
      |=> (wall_cnt == $past(wall_cnt) + 32'd1));

   p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (link_clk_en && bclk_tick && !tst_load && wall_cnt == 32'hFFFF_FFFF)
      |=> (wall_cnt == 32'd0));

   p_other_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && rd_addr != STATUS_OFS && rd_addr != CLOCK_OFS)
      |=> (rd_data == 32'd0));

   p_write_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && wr_en) |=> $stable(rd_data));
endmodule

bind audio_irq_aggregator aia_checker #(
   .NUM_STREAMS (NUM_STREAMS),
   .ADDR_W      (ADDR_W),
   .STATUS_OFS  (STATUS_OFS),
   .CLOCK_OFS   (CLOCK_OFS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .status_word (status_word),
   .global_sum  (global_sum),
   .irq_req     (irq_req),
   .stream_en   (stream_en),
   .ctrl_en     (ctrl_en),
   .glob_en     (glob_en),
   .link_clk_en (link_clk_en),
   .bclk_tick   (bclk_tick),
   .tst_load    (tst_load),
   .rd_en       (rd_en),
   .wr_en       (wr_en),
   .rd_addr     (rd_addr),
   .rd_data     (rd_data),
   .wall_cnt    (wall_cnt)
);

// File: tb/audio_irq_aggregator_bench.sv
module audio_irq_aggregator_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] in_src = '0;
   logic [11:0] out_src = '0;
   logic        rsp_irq = 0, rsp_ovr = 0, sdin_chg = 0;
   logic [7:0]  stream_en = '0;
   logic        ctrl_en = 0, glob_en = 0;
   logic        link_clk_en = 0, bclk_tick = 0, tst_load = 0;
   logic [31:0] tst_value = '0;
   logic        rd_en = 0, wr_en = 0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data, status_word;
   logic        global_sum, irq_req;

   int n_checks = 0;
   int n_errs   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   audio_irq_aggregator u_audio_irq_aggregator (
      .clk(clk), .rst_n(rst_n), .in_src(in_src), .out_src(out_src),
      .rsp_irq(rsp_irq), .rsp_ovr(rsp_ovr), .sdin_chg(sdin_chg),
      .stream_en(stream_en), .ctrl_en(ctrl_en), .glob_en(glob_en),
      .link_clk_en(link_clk_en), .bclk_tick(bclk_tick),
      .tst_load(tst_load), .tst_value(tst_value),
      .rd_en(rd_en), .wr_en(wr_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .status_word(status_word),
      .global_sum(global_sum), .irq_req(irq_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_word(input logic [7:0] sb, input logic cb);
      return {(cb | (|sb)), cb, 22'd0, sb};
   endfunction

   // one bus read, ticks must be handled by the caller
   task automatic do_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      @(posedge clk); #1;
      d = rd_data;
      rd_en = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_errs++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [31:0] v;

      // R7 reset state
      repeat (3) @(posedge clk);
      #1;
      chk("R7 rd_data in reset", rd_data, 32'd0);
      chk("R7 irq in reset", {31'd0, irq_req}, 32'd0);
      @(negedge clk); rst_n = 1'b1;
      do_read(8'h30, d);
      chk("R7 wall clock after reset", d, 32'd0);

      // R1 single-source sweep, every source of every stream
      glob_en = 1'b1; stream_en = 8'hFF;
      for (int i = 0; i < 24; i++) begin
         @(negedge clk);
         {out_src, in_src} = 24'd1 << i;
         @(posedge clk); #1;
         chk("R1 stream bit position", status_word, exp_word(8'd1 << (i/3), 1'b0));
         chk("R6 irq enabled stream", {31'd0, irq_req}, 32'd1);
      end

      // R2 controller sources, all 8 combinations, with and without enable
      @(negedge clk); {out_src, in_src} = '0; stream_en = '0;
      for (int c = 0; c < 16; c++) begin
         @(negedge clk);
         {rsp_irq, rsp_ovr, sdin_chg} = c[2:0];
         ctrl_en = c[3];
         @(posedge clk); #1;
         chk("R2 controller bit", status_word, exp_word(8'd0, |c[2:0]));
         chk("R6 controller gating", {31'd0, irq_req}, {31'd0, (|c[2:0]) & c[3]});
      end

      // R5/R6/R3/R4 exhaustive stream patterns against a shifting enable mask
      @(negedge clk); {rsp_irq, rsp_ovr, sdin_chg} = 3'b000; ctrl_en = 1'b0;
      for (int p = 0; p < 256; p++) begin
         logic [7:0]  en;
         logic [23:0] s;
         en = 8'(p * 37 + 11);
         s = '0;
         for (int k = 0; k < 8; k++) if (p[k]) s[k*3 + (k % 3)] = 1'b1;
         @(negedge clk);
         {out_src, in_src} = s;
         stream_en = en;
         glob_en = (p % 5) != 0;
         @(posedge clk); #1;
         chk("R5 status ignores enables", status_word, exp_word(8'(p), 1'b0));
         chk("R3 global summary", {31'd0, global_sum}, {31'd0, (p != 0)});
         chk("R6 gated irq", {31'd0, irq_req},
             {31'd0, ((p % 5) != 0) & (|(8'(p) & en))});
      end

      // R6 set status with enable clear raises nothing
      @(negedge clk);
      {out_src, in_src} = 24'h800001; stream_en = 8'h7E; glob_en = 1'b1;
      @(posedge clk); @(posedge clk); #1;
      chk("R6 status set, enable clear", {31'd0, irq_req}, 32'd0);
      do_read(8'h24, d);
      chk("R10 status read", d, exp_word(8'h81, 1'b0));
      chk("R4 reserved bits", {10'd0, d[29:8]}, 32'd0);

      // R12 preload, then R8 read and increment on the same edge, R9 wrap
      v = 32'hFFFF_FFFE;
      @(negedge clk); tst_load = 1'b1; tst_value = v;
      @(negedge clk); tst_load = 1'b0; link_clk_en = 1'b1; bclk_tick = 1'b1;
      rd_en = 1'b1; rd_addr = 8'h30;
      @(posedge clk); #1;
      chk("R8 read sees pre-increment value", rd_data, v);
      rd_en = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk); bclk_tick = 1'b0;
      do_read(8'h30, d);
      chk("R9 wrap through zero", d, 32'd2);

      // R8 freeze while link clock disabled
      @(negedge clk); link_clk_en = 1'b0; bclk_tick = 1'b1;
      repeat (10) @(posedge clk);
      @(negedge clk); bclk_tick = 1'b0;
      do_read(8'h30, d);
      chk("R8 frozen when link clock off", d, 32'd2);

      // R8 counts only on ticks
      @(negedge clk); link_clk_en = 1'b1;
      repeat (5) @(posedge clk);
      @(negedge clk); bclk_tick = 1'b1;
      repeat (6) @(posedge clk);
      @(negedge clk); bclk_tick = 1'b0;
      do_read(8'h30, d);
      chk("R8 one step per tick", d, 32'd8);

      // R12 load wins over a concurrent tick
      @(negedge clk); tst_load = 1'b1; tst_value = 32'd5; bclk_tick = 1'b1;
      @(negedge clk); tst_load = 1'b0; bclk_tick = 1'b0;
      do_read(8'h30, d);
      chk("R12 load priority", d, 32'd5);

      // R11 writes ignored
      @(negedge clk); rd_en = 1'b1; wr_en = 1'b1; rd_addr = 8'h24;
      @(posedge clk); #1;
      chk("R11 write leaves rd_data", rd_data, 32'd5);
      @(negedge clk); rd_addr = 8'h30;
      @(posedge clk); #1;
      rd_en = 1'b0; wr_en = 1'b0;
      chk("R11 write leaves rd_data", rd_data, 32'd5);
      chk("R11 write leaves status", status_word, exp_word(8'h81, 1'b0));
      do_read(8'h30, d);
      chk("R11 write leaves wall clock", d, 32'd5);

      // R10 every other offset reads zero
      for (int a = 0; a < 256; a++) begin
         if (a != 'h24 && a != 'h30) begin
            do_read(8'(a), d);
            chk("R10 unmapped offset", d, 32'd0);
         end
      end

      // R7 reset mid-run clears everything
      @(negedge clk); rst_n = 1'b0;
      #1;
      chk("R7 rd_data on reset", rd_data, 32'd0);
      chk("R7 irq on reset", {31'd0, irq_req}, 32'd0);
      @(negedge clk); rst_n = 1'b1; link_clk_en = 1'b0;
      do_read(8'h30, d);
      chk("R7 wall clock cleared", d, 32'd0);

      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end
endmodule